// File: doc/BRIEF.md
# Periodic Down-Counting Timer Channel

This block is a single 32-bit timer channel for a peripheral cluster. A prescaler divides the peripheral clock by one of five power-of-four ratios. Each divided tick lowers a live counter by one. When a tick arrives with the counter already at zero, the counter takes the reload value and keeps counting, so the channel fires at a fixed period. Each such wrap also sets a sticky wrap flag. An interrupt line is driven from that flag, gated by an enable bit.

Software reaches the channel through single-cycle read and write strobes on a word-addressed register window. An external `start` level gates all counting. The channel rejects illegal control words and illegal offsets and pulses an error output for each one. A build-time switch adds a plain storage register at the fourth slot; no input-capture sampling goes with it.

Top module: `rtimer`

## Requirements
- R1: After reset the reload register reads 0, the counter reads 0xFFFFFFFF, the control register reads 0, and `irq` and `err` are low.
- R2: Word offsets are fixed: 0x0 is the reload value, 0x4 the counter, 0x8 control, and 0xC the optional spare register. A write to offset 0x0 or 0x4 reads back unchanged.
- R3: The control divisor code is in bits 2:0. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks while started. The counter drops by one on each tick.
- R4: A tick with the counter at 0 loads the reload value and sets the wrap flag, which reads in control bit 8.
- R5: The prescaler and the counter advance only in cycles where `start` is high. Otherwise both hold their values.
- R6: `irq` is high exactly when the wrap flag is set and the interrupt enable in control bit 5 is set.
- R7: A legal control write with bit 8 at 0 clears the wrap flag. With bit 8 at 1, the flag keeps its value.
- R8: A control word is illegal if any of the following holds: it has a divisor code of 5 to 7, nonzero bits 4:3, value 1 in bits 7:6, any of bits 31:10 set, or, without the spare register, nonzero bits 7:6 or bit 9 set. An illegal word is not stored, and `err` is high in the next cycle.
- R9: An access with `addr[1:0]` nonzero, or to 0xC without the spare register, raises `err` for one cycle. Such a read returns 0 and such a write changes nothing.
- R10: A control write holds the counter and the prescaler for its own cycle and keeps the count. The prescaler phase restarts from zero only when the divisor code changes.
- R11: A counter write wins over a tick in the same cycle. The written value is stored, and no decrement or wrap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Counting enable level |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 4 | Byte offset into the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when not reading |
| irq | output | 1 | Wrap interrupt request |
| err | output | 1 | One-cycle pulse after an illegal access or control word |

## Verification
The embedded properties check on every cycle that the counter either decrements, reloads on a tick at zero, or holds. They also check that the flag stays set until a clearing write, that a rejected control word leaves the control state alone, and that a control write freezes the count. Only the scenarios can show the following: the exact tick spacing for each divisor code, the read-back encoding of the flag and the control fields, phase restart against phase keep on a control write, and a counter write colliding with a tick. For these the bench runs its own cycle model and compares `irq` and `err` on every clock and `rdata` on every read.

// File: rtl/rtimer_pkg.sv
// Shared definitions for the periodic timer channel: register slots,
// control field layout, and the legality and divisor helpers.
// Assumes a 32-bit bus and byte addressing of 32-bit words.
package rtimer_pkg;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 4;
    localparam int DIV_CODES = 5;
    localparam int PH_W      = 2 * DIV_CODES;
    localparam logic [BUS_W-1:0] CNT_RESET = 32'hFFFF_FFFF;
    localparam logic [BUS_W-1:0] SPARE_RESET = 32'hDEAD_BEEF;

    typedef enum logic [1:0] {
        SLOT_RELOAD = 2'd0,
        SLOT_COUNT  = 2'd1,
        SLOT_CTRL   = 2'd2,
        SLOT_SPARE  = 2'd3
    } slot_e;

    // Stored part of the control word, bits 7:0.
    typedef struct packed {
        logic [1:0] cap_mode;
        logic       irq_en;
        logic [1:0] edge_sel;
        logic [2:0] div_sel;
    } ctrl_t;

    // True when a control word may be stored.
    function automatic logic ctrl_ok(input logic [BUS_W-1:0] v, input logic has_spare);
        logic ok;
        ok = (v[BUS_W-1:10] == '0) && (v[2:0] <= 3'd4) &&
             (v[4:3] == 2'b00) && (v[7:6] != 2'b01);
        if (!has_spare)
            ok = ok && (v[7:6] == 2'b00) && !v[9];
        return ok;
    endfunction

    // Last phase value before a tick for a given divisor code.
    function automatic logic [PH_W-1:0] phase_limit(input logic [2:0] code);
        logic [PH_W-1:0] one;
        one = PH_W'(1);
        return (one << (2 + 2 * int'(code))) - PH_W'(1);
    endfunction
endpackage

// File: rtl/rtimer_prescaler.sv
// Divides the clock by the selected power of four and emits a one-cycle
// tick at the end of each period. Assumes div_sel holds a legal code.
module rtimer_prescaler
    import rtimer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [2:0] div_sel,
    output logic       tick
);
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] limit;

    assign limit = phase_limit(div_sel);
    assign tick  = run && !clear && (phase == limit);

    // Phase counter: restart on divisor change, advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (clear)
            phase <= '0;
        else if (run)
            phase <= (phase == limit) ? '0 : phase + 1'b1;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(phase)); // R5
endmodule

// File: rtl/rtimer_counter.sv
// Live down-counter with reload on wrap and the sticky wrap flag.
// Assumes a bus load and a flag clear never arrive with a tick from a
// held cycle; a load always wins over a tick.
module rtimer_counter
    import rtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic [BUS_W-1:0] load_val,
    input  logic [BUS_W-1:0] reload_val,
    input  logic             flag_clr,
    output logic [BUS_W-1:0] count,
    output logic             uflag
);
    logic wrap;

    assign wrap = tick && !load_we && (count == '0);

    // Count register: bus load, reload on wrap, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CNT_RESET;
        else if (load_we)
            count <= load_val;
        else if (wrap)
            count <= reload_val;
        else if (tick)
            count <= count - 1'b1;
    end

    // Wrap flag: set by hardware, cleared only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uflag <= 1'b0;
        else if (wrap)
            uflag <= 1'b1;
        else if (flag_clr)
            uflag <= 1'b0;
    end

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && count == '0) |=> (count == $past(reload_val)) && uflag); // R4
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && count != '0) |=> count == $past(count) - 1'b1); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(count)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uflag && !flag_clr) |=> uflag); // R7
endmodule

// File: rtl/rtimer_regs.sv
// Register window: decodes strobes, holds reload, control and the
// optional spare word, drives read data and the error pulse.
// Assumes single-cycle strobes; rdata is combinational.
module rtimer_regs
    import rtimer_pkg::*;
#(
    parameter bit HAS_SPARE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  count,
    input  logic              uflag,
    output logic [BUS_W-1:0]  reload_val,
    output ctrl_t             ctrl_q,
    output logic              cnt_we,
    output logic              ctrl_wr,
    output logic              flag_clr,
    output logic              ps_clear,
    output logic [BUS_W-1:0]  rdata,
    output logic              err
);
    slot_e            slot;
    logic             exists;
    logic             ctrl_good;
    logic [BUS_W-1:0] spare_q;

    assign slot      = slot_e'(addr[3:2]);
    assign exists    = (addr[1:0] == 2'b00) && (HAS_SPARE || slot != SLOT_SPARE);
    assign ctrl_good = ctrl_ok(wdata, HAS_SPARE);
    assign cnt_we    = wr_en && exists && (slot == SLOT_COUNT);
    assign ctrl_wr   = wr_en && exists && (slot == SLOT_CTRL);
    assign flag_clr  = ctrl_wr && ctrl_good && !wdata[8];
    assign ps_clear  = ctrl_wr && ctrl_good && (wdata[2:0] != ctrl_q.div_sel);

    // Reload register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_val <= '0;
        else if (wr_en && exists && slot == SLOT_RELOAD)
            reload_val <= wdata;
    end

    // Control register write, legal words only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr && ctrl_good)
            ctrl_q <= ctrl_t'(wdata[7:0]);
    end

    // Spare storage word, present only when configured.
    generate
        if (HAS_SPARE) begin : g_spare
            always_ff @(posedge clk) begin
                if (!rst_n)
                    spare_q <= SPARE_RESET;
                else if (wr_en && exists && slot == SLOT_SPARE)
                    spare_q <= wdata;
            end
        end else begin : g_no_spare
            assign spare_q = SPARE_RESET;
        end
    endgenerate

    // Error pulse one cycle after a bad offset or a rejected control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else
            err <= ((wr_en || rd_en) && !exists) || (ctrl_wr && !ctrl_good);
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (rd_en && exists) begin
            case (slot)
                SLOT_RELOAD: rdata = reload_val;
                SLOT_COUNT:  rdata = count;
                SLOT_CTRL:   rdata = {22'b0, 1'b0, uflag, ctrl_q};
                default:     rdata = spare_q;
            endcase
        end
    end

    AST_BAD_CTRL_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_good) |=> $stable(ctrl_q)); // R8
    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en || rd_en)); // R9
endmodule

// File: rtl/rtimer.sv
// Top of the periodic timer channel: joins the register window, the
// prescaler and the counter. Counting is frozen during a control write.
module rtimer
    import rtimer_pkg::*;
#(
    parameter bit HAS_SPARE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        err
);
    logic [BUS_W-1:0] count;
    logic [BUS_W-1:0] reload_val;
    ctrl_t            ctrl_q;
    logic             uflag;
    logic             cnt_we;
    logic             ctrl_wr;
    logic             flag_clr;
    logic             ps_clear;
    logic             run;
    logic             tick;

    assign run = start && !ctrl_wr;
    assign irq = uflag && ctrl_q.irq_en;

    rtimer_regs #(.HAS_SPARE(HAS_SPARE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count(count), .uflag(uflag),
        .reload_val(reload_val), .ctrl_q(ctrl_q), .cnt_we(cnt_we),
        .ctrl_wr(ctrl_wr), .flag_clr(flag_clr), .ps_clear(ps_clear),
        .rdata(rdata), .err(err)
    );

    rtimer_prescaler u_pres (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(ps_clear),
        .div_sel(ctrl_q.div_sel), .tick(tick)
    );

    rtimer_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_we(cnt_we),
        .load_val(wdata), .reload_val(reload_val), .flag_clr(flag_clr),
        .count(count), .uflag(uflag)
    );

    AST_HOLD_ON_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !cnt_we) |=> $stable(count)); // R10
endmodule

// File: tb/rtimer_test.sv
module rtimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_rl, m_cn;
    logic [7:0]  m_cr;
    bit          m_fl, m_er;
    int          m_ph;

    always #5 clk = ~clk;

    rtimer uut (.clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
                .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
                .irq(irq), .err(err));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal_word(input logic [31:0] v);
        if (v[31:10] != 0 || v[9]) return 0;
        if (v[2:0] > 4 || v[4:3] != 0 || v[7:6] != 0) return 0;
        return 1;
    endfunction

    function automatic int period(input logic [2:0] code);
        return 4 ** (int'(code) + 1);
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        if (a[1:0] != 0) return 0;
        case (a[3:2])
            2'd0: return m_rl;
            2'd1: return m_cn;
            2'd2: return {23'b0, m_fl, m_cr};
            default: return 0;
        endcase
    endfunction

    // Reference model, one step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rl = 0; m_cn = 32'hFFFFFFFF; m_cr = 0; m_fl = 0; m_er = 0; m_ph = 0;
        end else begin
            bit ok_off, cwr, good, tck, cnt_w;
            ok_off = (addr[1:0] == 0) && (addr[3:2] != 3);
            cwr    = wr_en && ok_off && addr[3:2] == 2;
            cnt_w  = wr_en && ok_off && addr[3:2] == 1;
            good   = legal_word(wdata);
            m_er   = ((wr_en || rd_en) && !ok_off) || (cwr && !good);
            tck    = start && !cwr && (m_ph == period(m_cr[2:0]) - 1);
            if (cnt_w) m_cn = wdata;
            else if (tck) begin
                if (m_cn == 0) begin m_cn = m_rl; m_fl = 1; end
                else m_cn = m_cn - 1;
            end
            if (cwr && good && wdata[2:0] != m_cr[2:0]) m_ph = 0;
            else if (start && !cwr) m_ph = tck ? 0 : m_ph + 1;
            if (wr_en && ok_off && addr[3:2] == 0) m_rl = wdata;
            if (cwr && good) begin
                m_cr = wdata[7:0];
                if (!wdata[8]) m_fl = 0;
            end
        end
    end

    // Per-cycle comparison of the always-visible outputs.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == (m_fl && m_cr[5]), "R6 irq per cycle", {31'b0, irq}, {31'b0, m_fl && m_cr[5]});
            chk(err == m_er, "R8 R9 err per cycle", {31'b0, err}, {31'b0, m_er});
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = 0; wdata = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
        chk(rdata == m_read(a), {tag, " model"}, rdata, m_read(a));
        @(negedge clk);
        rd_en = 0; addr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] bad [7];
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && err == 0, "R1 irq/err at reset", {30'b0, irq, err}, 0);
        bus_rd(4'h0, "R1 reload reset", 0);
        bus_rd(4'h4, "R1 counter reset", 32'hFFFFFFFF);
        bus_rd(4'h8, "R1 control reset", 0);
        // R2 register map
        bus_wr(4'h0, 32'h1234_5678);
        bus_rd(4'h0, "R2 reload readback", 32'h1234_5678);
        bus_wr(4'h4, 32'h0BAD_F00D);
        bus_rd(4'h4, "R2 counter readback", 32'h0BAD_F00D);
        bus_wr(4'h0, 0);
        // R3 divisor codes
        for (int k = 0; k < 5; k++) begin
            bus_wr(4'h8, 32'((k + 1) % 5));
            bus_wr(4'h8, 32'(k));
            bus_wr(4'h4, 100);
            @(negedge clk); start = 1;
            repeat (2 * period(3'(k))) @(negedge clk);
            start = 0;
            bus_rd(4'h4, $sformatf("R3 count after two periods code %0d", k), 98);
        end
        // R4 wrap and reload, R6 irq
        bus_wr(4'h0, 5);
        bus_wr(4'h4, 2);
        bus_wr(4'h8, 32'h20);
        @(negedge clk); start = 1;
        repeat (12) @(negedge clk);
        start = 0;
        bus_rd(4'h4, "R4 reloaded count", 5);
        bus_rd(4'h8, "R4 flag in bit 8", 32'h120);
        chk(irq == 1, "R6 irq with flag and enable", {31'b0, irq}, 1);
        bus_wr(4'h8, 32'h100);
        chk(irq == 0, "R6 irq masked by enable", {31'b0, irq}, 0);
        bus_rd(4'h8, "R7 flag kept by writing 1", 32'h100);
        bus_wr(4'h8, 32'h120);
        chk(irq == 1, "R6 irq re-enabled", {31'b0, irq}, 1);
        bus_wr(4'h8, 32'h020);
        chk(irq == 0, "R7 irq after clear", {31'b0, irq}, 0);
        bus_rd(4'h8, "R7 flag cleared by writing 0", 32'h020);
        // R5 hold while stopped
        repeat (50) @(negedge clk);
        bus_rd(4'h4, "R5 count held while stopped", 5);
        // R8 illegal control words
        bad[0] = 32'h05; bad[1] = 32'h07; bad[2] = 32'h08; bad[3] = 32'h40;
        bad[4] = 32'h80; bad[5] = 32'h200; bad[6] = 32'h10400;
        for (int i = 0; i < 7; i++) begin
            bus_wr(4'h8, bad[i]);
            chk(err == 1, $sformatf("R8 err for word %h", bad[i]), {31'b0, err}, 1);
        end
        bus_rd(4'h8, "R8 control unchanged", 32'h020);
        // R9 illegal offsets
        bus_rd(4'hC, "R9 missing slot reads 0", 0);
        chk(err == 1, "R9 err after bad read", {31'b0, err}, 1);
        bus_wr(4'h1, 32'h77);
        chk(err == 1, "R9 err after misaligned write", {31'b0, err}, 1);
        bus_wr(4'hC, 32'h77);
        chk(err == 1, "R9 err after missing slot write", {31'b0, err}, 1);
        bus_rd(4'h0, "R9 reload untouched", 5);
        // R10 control write while running
        bus_wr(4'h0, 1000);
        bus_wr(4'h4, 500);
        bus_wr(4'h8, 32'h02);
        @(negedge clk); start = 1;
        repeat (100) @(negedge clk);
        bus_wr(4'h8, 32'h02);
        bus_rd(4'h4, "R10 count after same-code write", m_cn);
        repeat (37) @(negedge clk);
        bus_wr(4'h8, 32'h01);
        repeat (20) @(negedge clk);
        bus_rd(4'h4, "R10 count after code change", m_cn);
        start = 0;
        @(negedge clk);
        bus_rd(4'h4, "R10 count stopped", m_cn);
        // R11 counter write in a tick cycle
        bus_wr(4'h8, 32'h00);
        @(negedge clk); start = 1;
        while (m_ph != 3) @(negedge clk);
        wr_en = 1; addr = 4'h4; wdata = 77;
        @(negedge clk);
        wr_en = 0; addr = 0; wdata = 0; start = 0;
        bus_rd(4'h4, "R11 write wins over tick", 77);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule